// File: doc/BRIEF.md
# Edge-Timed Noise Entropy Collector

This block turns a digital noise signal arriving from outside the chip into 32-bit entropy words. The noise pin is asynchronous to the core clock, so it is first brought into the clock domain through a chain of flip-flops. Each rising transition of the synchronised noise is then timestamped against a counter that advances on every core clock cycle. Only the parity of that counter at the moment of the transition is kept. These single bits are shifted into a word register, and once enough fresh bits have been gathered the word is offered to a consumer over a valid/acknowledge handshake. While the word is on offer, new bits keep being gathered.

A second counter measures how many cycles separate consecutive rising transitions and publishes that figure as a test output, so that the spacing of noise events can be observed in the lab. Because a bit depends only on when a rising transition happens, and not on how long the noise stays high or low, a level bias in the source does not bias the produced bits.

Collection is controlled by a three-state machine. IDLE holds while collection is disabled. COLLECT counts fresh bits. READY holds a finished word on the output. The transitions are as follows. IDLE to COLLECT happens when enable is high. COLLECT to READY happens on the edge that completes the word. READY to COLLECT happens on acknowledge. From COLLECT or READY, the machine returns to IDLE whenever enable is low.

Top module: `edge_entropy_collector`

## Requirements
- R1: The noise input passes through two flip-flops in series, and the previous synchronised value is registered once more. A change on `noise_in` that is set up before clock edge 1 is therefore acted on at clock edge 3: it shifts a bit and updates `delta_time` there.
- R2: Only a rising transition (previous synchronised sample 0, current sample 1) produces a bit or updates `delta_time`. A falling transition changes neither output.
- R3: A free-running counter is cleared by reset and increments on every clock after reset. The bit taken at a rising transition is that counter's least significant bit in the cycle where the transition is detected.
- R4: Bits enter at bit 0 and move toward bit 31, so the oldest bit ends up in the MSB. On the clock edge that shifts in the 32nd counted bit, `entropy_data` loads the 32 most recent bits and `entropy_valid` rises. No word is offered after only 31 bits.
- R5: While `entropy_valid` is high, `entropy_data` holds its value. Rising transitions in this period are still shifted into the internal register but are not counted toward the next word.
- R6: When `entropy_ack` is high while `entropy_valid` is high, `entropy_valid` is low after the next clock edge and the bit count restarts. A rising transition detected in that same acknowledge cycle counts as the first bit of the next word.
- R7: At each rising transition, `delta_time` loads the number of cycles since the previous detected transition. For the first transition after reset, it loads the number of cycles since reset ended.
- R8: The interval counter saturates at its all-ones value instead of wrapping. A narrower `DELTA_W` therefore reports all ones for long gaps.
- R9: While `enable` is low, no bits are shifted, `entropy_valid` is low after the next clock edge, and the bit count is cleared. After `enable` rises, the machine spends one cycle in IDLE and then counts from zero in COLLECT.
- R10: Changing the time the noise stays high or low does not change the produced bits, as long as the rising transitions occur in the same cycles.
- R11: Reset clears the synchroniser, both counters, the shift register, `entropy_data`, `delta_time` and `entropy_valid` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Collection enable |
| noise_in | input | 1 | Asynchronous digital noise |
| entropy_data | output | 32 | Offered entropy word |
| entropy_valid | output | 1 | Word on offer |
| entropy_ack | input | 1 | Consumer acknowledges the word |
| delta_time | output | 32 | Cycles between the last two rising transitions |

## Verification
The assertions assume that `entropy_ack` is raised only while a word is on offer. They also assume that `enable` and `entropy_ack` are synchronous to the core clock. The bench drives both strictly between clock edges and raises acknowledge only after it has seen `entropy_valid` high. It holds every noise level for at least two cycles, so each rising transition crosses the synchroniser and is seen exactly once. This makes each edge's bit and interval predictable from a cycle count that the bench keeps itself.

// File: rtl/edge_entropy_pkg.sv
package edge_entropy_pkg;

    // Collection controller states
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_READY   = 2'd2
    } coll_state_t;

    localparam int DEFAULT_WORD_W  = 32;
    localparam int DEFAULT_DELTA_W = 32;
    localparam int DEFAULT_FREE_W  = 16;
    localparam int DEFAULT_SYNC_N  = 2;

endpackage

// File: rtl/noise_edge_sync.sv
module noise_edge_sync #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic noise_in,
    output logic rise
);

    logic [SYNC_N-1:0] chain_q;
    logic              prev_q;

    // Synchroniser chain, one flop per stage
    for (genvar g = 0; g < SYNC_N; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else        chain_q[g] <= noise_in;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    end

    // Previous synchronised sample for phase comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[SYNC_N-1];
    end

    assign rise = chain_q[SYNC_N-1] & ~prev_q;

endmodule

// File: rtl/edge_interval_timer.sv
module edge_interval_timer #(
    parameter int FREE_W  = 16,
    parameter int DELTA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rise,
    output logic               sample_bit,
    output logic [DELTA_W-1:0] delta_time
);

    localparam logic [DELTA_W-1:0] DELTA_MAX = {DELTA_W{1'b1}};

    logic [FREE_W-1:0]  free_q;
    logic [DELTA_W-1:0] gap_q;

    // Free-running cycle counter; only its parity is consumed
    always_ff @(posedge clk) begin
        if (!rst_n) free_q <= '0;
        else        free_q <= free_q + FREE_W'(1);
    end

    assign sample_bit = free_q[0];

    // Interval counter with saturation, restarts at one on each rise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q      <= '0;
            delta_time <= '0;
        end else if (rise) begin
            delta_time <= gap_q;
            gap_q      <= DELTA_W'(1);
        end else if (gap_q != DELTA_MAX) begin
            gap_q      <= gap_q + DELTA_W'(1);
        end
    end

endmodule

// File: rtl/entropy_word_fsm.sv
module entropy_word_fsm
    import edge_entropy_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              rise,
    input  logic              sample_bit,
    input  logic              ack,
    output logic [WORD_W-1:0] word,
    output logic              valid
);

    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    coll_state_t       state_q, state_d;
    logic [CNT_W-1:0]  count_q;
    logic [WORD_W-1:0] shift_q;
    logic [WORD_W-1:0] shift_next;
    logic              take_bit;

    assign take_bit   = enable & rise;
    assign shift_next = {shift_q[WORD_W-2:0], sample_bit};

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (enable) state_d = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (!enable)                             state_d = ST_IDLE;
                else if (rise && (count_q == LAST_BIT))  state_d = ST_READY;
            end
            ST_READY: begin
                if (!enable)  state_d = ST_IDLE;
                else if (ack) state_d = ST_COLLECT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            count_q <= '0;
            word    <= '0;
        end else begin
            if (take_bit) shift_q <= shift_next;

            unique case (state_q)
                ST_IDLE: begin
                    count_q <= '0;
                end
                ST_COLLECT: begin
                    if (!enable) begin
                        count_q <= '0;
                    end else if (rise) begin
                        if (count_q == LAST_BIT) begin
                            count_q <= '0;
                            word    <= shift_next;
                        end else begin
                            count_q <= count_q + CNT_W'(1);
                        end
                    end
                end
                ST_READY: begin
                    if (enable && ack && rise) count_q <= CNT_W'(1);
                    else                       count_q <= '0;
                end
                default: count_q <= '0;
            endcase
        end
    end

    assign valid = (state_q == ST_READY);

endmodule

// File: rtl/edge_entropy_collector.sv
module edge_entropy_collector
    import edge_entropy_pkg::*;
#(
    parameter int WORD_W  = DEFAULT_WORD_W,
    parameter int DELTA_W = DEFAULT_DELTA_W,
    parameter int FREE_W  = DEFAULT_FREE_W,
    parameter int SYNC_N  = DEFAULT_SYNC_N
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               noise_in,
    output logic [WORD_W-1:0]  entropy_data,
    output logic               entropy_valid,
    input  logic               entropy_ack,
    output logic [DELTA_W-1:0] delta_time
);

    logic rise;
    logic sample_bit;

    noise_edge_sync #(.SYNC_N(SYNC_N)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .noise_in (noise_in),
        .rise     (rise)
    );

    edge_interval_timer #(.FREE_W(FREE_W), .DELTA_W(DELTA_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise       (rise),
        .sample_bit (sample_bit),
        .delta_time (delta_time)
    );

    entropy_word_fsm #(.WORD_W(WORD_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .rise       (rise),
        .sample_bit (sample_bit),
        .ack        (entropy_ack),
        .word       (entropy_data),
        .valid      (entropy_valid)
    );

endmodule

// File: rtl/edge_entropy_collector_chk.sv
module edge_entropy_collector_chk #(
    parameter int WORD_W  = 32,
    parameter int DELTA_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               enable,
    input logic               entropy_ack,
    input logic               entropy_valid,
    input logic [WORD_W-1:0]  entropy_data,
    input logic [DELTA_W-1:0] delta_time,
    input logic               rise,
    input logic               sample_bit
);

    // R9: disabling removes the offered word on the next edge
    assert_valid_off_when_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !entropy_valid);

    // R6: an accepted word is withdrawn on the next edge
    assert_ack_withdraws_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (entropy_valid && entropy_ack) |=> !entropy_valid);

    // R5: the offered word does not move while on offer
    assert_word_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        entropy_valid |=> $stable(entropy_data));

    // R7: the interval output only moves on a detected rise
    assert_delta_only_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(delta_time));

    // R4: a word is offered only on the edge that consumed a rise
    assert_word_after_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(entropy_valid) |-> $past(rise));

    // R3: the counter parity flips every cycle
    assert_parity_toggles_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (sample_bit != $past(sample_bit)));

endmodule

bind edge_entropy_collector edge_entropy_collector_chk #(
    .WORD_W  (WORD_W),
    .DELTA_W (DELTA_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .entropy_ack   (entropy_ack),
    .entropy_valid (entropy_valid),
    .entropy_data  (entropy_data),
    .delta_time    (delta_time),
    .rise          (rise),
    .sample_bit    (sample_bit)
);

// File: tb/edge_entropy_collector_bench.sv
module edge_entropy_collector_bench;

    localparam int NARROW_W = 5;
    localparam int NARROW_MAX = (1 << NARROW_W) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        noise = 1'b0;
    logic        ack = 1'b0;
    logic [31:0] data;
    logic        valid;
    logic [31:0] delta;
    logic [31:0] data_n;
    logic        valid_n;
    logic [NARROW_W-1:0] delta_n;

    always #2 clk = ~clk;

    edge_entropy_collector u_edge_entropy_collector (
        .clk(clk), .rst_n(rst_n), .enable(enable), .noise_in(noise),
        .entropy_data(data), .entropy_valid(valid), .entropy_ack(ack),
        .delta_time(delta)
    );

    edge_entropy_collector #(.DELTA_W(NARROW_W)) u_edge_entropy_collector_narrow (
        .clk(clk), .rst_n(rst_n), .enable(enable), .noise_in(noise),
        .entropy_data(data_n), .entropy_valid(valid_n), .entropy_ack(ack),
        .delta_time(delta_n)
    );

    // Model state, built from the requirements
    int          tb_cnt = 0;
    int          last_det = 0;
    int          cnt = 0;
    bit          counting = 1'b0;
    bit          ready_m = 1'b0;
    logic [31:0] hist = '0;
    logic [31:0] exp_q[$];
    int          n_checks = 0;
    int          n_fail = 0;
    bit          prev_valid = 1'b0;
    bit          finished = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) tb_cnt <= 0;
        else        tb_cnt <= tb_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: compares each newly offered word against the scoreboard
    always @(negedge clk) begin
        if (rst_n && valid && !prev_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 unexpected word", data, 32'h0);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                chk(data == e, "R4 R3 word content", data, e);
            end
        end
        prev_valid = valid;
    end

    // Driver: one noise pulse, hi cycles high then lo cycles low
    task automatic pulse(input int hi, input int lo, input bit ack_here);
        int dexp;
        int nexp;
        @(negedge clk) noise = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        // detection cycle (R1: edge shifts on the third clock edge)
        if (ack_here) ack = 1'b1;
        dexp = tb_cnt - last_det;
        last_det = tb_cnt;
        nexp = (dexp > NARROW_MAX) ? NARROW_MAX : dexp;
        if (enable) begin
            hist = {hist[30:0], tb_cnt[0]};
            if (ack_here) begin
                counting = 1'b1;
                ready_m = 1'b0;
                cnt = 0;
            end
            if (counting) begin
                cnt++;
                if (cnt == 32) begin
                    exp_q.push_back(hist);
                    counting = 1'b0;
                    ready_m = 1'b1;
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        ack = 1'b0;
        chk(delta == 32'(dexp), "R7 interval", delta, 32'(dexp));
        chk(32'(delta_n) == 32'(nexp), "R8 saturating interval", 32'(delta_n), 32'(nexp));
        chk(valid == ready_m, "R4 valid timing", 32'(valid), 32'(ready_m));
        repeat (hi - 2) @(negedge clk);
        noise = 1'b0;
        repeat (lo) @(negedge clk);
        chk(delta == 32'(dexp), "R2 fall leaves interval", delta, 32'(dexp));
    endtask

    task automatic burst(input int n, input int hi, input int lo);
        for (int i = 0; i < n; i++) pulse(hi, lo, 1'b0);
    endtask

    task automatic do_ack();
        @(negedge clk) ack = 1'b1;
        @(negedge clk) ack = 1'b0;
        chk(valid == 1'b0, "R6 valid drops after ack", 32'(valid), 32'h0);
        ready_m = 1'b0;
        counting = 1'b1;
        cnt = 0;
    endtask

    task automatic set_enable(input bit v);
        @(negedge clk) enable = v;
        @(negedge clk);
        if (!v) begin
            chk(valid == 1'b0, "R9 valid low when disabled", 32'(valid), 32'h0);
            counting = 1'b0;
            ready_m = 1'b0;
            cnt = 0;
        end else begin
            @(negedge clk);
            counting = 1'b1;
            cnt = 0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(valid == 1'b0, "R11 valid after reset", 32'(valid), 32'h0);
        chk(data == 32'h0, "R11 data after reset", data, 32'h0);
        chk(delta == 32'h0, "R11 delta after reset", delta, 32'h0);

        // R9: edges while disabled shift nothing; long gap saturates narrow (R8)
        pulse(3, 40, 1'b0);
        pulse(2, 4, 1'b0);
        chk(valid == 1'b0, "R9 no word while disabled", 32'(valid), 32'h0);

        set_enable(1'b1);
        burst(32, 2, 5);
        chk(exp_q.size() == 0, "R4 first word delivered", 32'(exp_q.size()), 32'h0);

        // R5: hold the word while more edges arrive
        held = data;
        burst(3, 3, 4);
        chk(data == held, "R5 word held while offered", data, held);
        chk(valid == 1'b1, "R5 still offered", 32'(valid), 32'h1);
        do_ack();

        // R10: long high, short low, same period as before
        burst(32, 6, 1);
        do_ack();

        // R9: partial word, disable clears the count
        burst(10, 2, 4);
        set_enable(1'b0);
        pulse(2, 4, 1'b0);
        set_enable(1'b1);
        burst(31, 3, 3);
        chk(valid == 1'b0, "R4 no word after 31 bits", 32'(valid), 32'h0);
        burst(1, 3, 3);
        chk(valid == 1'b1, "R4 word after 32 bits", 32'(valid), 32'h1);

        // R9: disable while a word is offered
        set_enable(1'b0);
        set_enable(1'b1);

        // R6: edge detected in the acknowledge cycle counts as first bit
        burst(32, 2, 3);
        pulse(2, 3, 1'b1);
        chk(valid == 1'b0, "R6 ack with edge", 32'(valid), 32'h0);
        burst(30, 2, 3);
        chk(valid == 1'b0, "R6 31 bits after ack", 32'(valid), 32'h0);
        burst(1, 2, 3);
        chk(valid == 1'b1, "R6 word after ack edge plus 31", 32'(valid), 32'h1);
        do_ack();

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R4 all words delivered", 32'(exp_q.size()), 32'h0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule